// File: doc/BRIEF.md
# Audio Infoframe Packet Generator

This block keeps the host-visible fields of an audio infoframe and turns them into a complete 14-byte packet when the periodic packet scheduler opens a slot. The host writes only the five meaningful data bytes. The block adds the fixed header itself and produces the checksum in hardware. It also rewrites the two fields that the downstream transmit path supports in only one form: the channel count and the channel allocation.

A packet-control write sets an enable bit and a repeat bit. A slot request (`frame_tick`) that arrives while the block is enabled and idle starts a packet. The packet then leaves one byte per clock with `out_valid` held high, and `out_last` marks the final byte. With repeat set, every later slot request sends the packet again. Without repeat, the packet goes out once and the block disables itself.

Top module: `aif_pkt_gen`

## Requirements
- R1: The first three bytes of every packet are 0x84, 0x01 and 0x0A, in that order.
- R2: A packet is 14 bytes on 14 consecutive cycles: the three header bytes, the checksum, then data bytes 1 to 10. `out_last` is high only on data byte 10, and `out_valid` is low between packets.
- R3: The checksum byte (fourth byte) makes the 8-bit sum of all 14 transmitted bytes equal zero.
- R4: Data bytes 6 to 10 are always transmitted as 0x00.
- R5: Data byte 4 is sent as 0x13 whenever the written value is nonzero, and as 0x00 when it is zero. The checksum covers the substituted value.
- R6: Data byte 1 keeps bits 7:3 as written. Its bits 2:0 (channel count) are sent as 7 when the written count is 2 to 6, and unchanged when it is 0, 1 or 7. The checksum covers the sent value.
- R7: A packet starts on the cycle after `frame_tick` is sampled high while enable is set and no packet is in flight. With enable clear, `frame_tick` produces no output.
- R8: With repeat set, enable stays set after a packet, so each later slot request sends a full packet.
- R9: With repeat clear, enable is cleared when the last byte is sent, and later slot requests produce no output until the host enables the block again.
- R10: A `frame_tick` that arrives while a packet is in flight is ignored. The packet neither restarts nor grows longer.
- R11: After reset, `out_valid` is low, enable and repeat are clear, and all data bytes hold 0x00. This gives checksum 0x71 for the first packet after enabling.
- R12: `fld_sel` values 0 to 4 write data bytes 1 to 5. Data bytes written with `fld_we` are used from the next packet on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fld_we | input | 1 | Write strobe for one data byte |
| fld_sel | input | 3 | Data byte select, 0..4 for bytes 1..5 |
| fld_wdata | input | 8 | Data byte value |
| ctl_we | input | 1 | Write strobe for packet control |
| ctl_enable | input | 1 | Enable value written with ctl_we |
| ctl_repeat | input | 1 | Repeat value written with ctl_we |
| frame_tick | input | 1 | Slot request from the packet scheduler |
| out_valid | output | 1 | Packet byte present |
| out_byte | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The bench attacks the boundaries of the channel-count rewrite at counts 1, 2 and 7, and the zero and nonzero cases of the allocation byte. A design with these boundaries off by one would send an 8-channel code for a stereo stream, or leave a 3-channel count unrewritten. Every packet's checksum is checked against the rewritten bytes: a design that summed the raw host values would send a packet that does not sum to zero. The bench also checks that a one-shot packet disables the block, so that no second packet leaks out. It sends a slot request in mid-packet, where a design that restarted the sequence would produce a packet longer than 14 bytes.

// File: rtl/aif_pkg.sv
package aif_pkg;
  localparam int AIF_BW         = 8;
  localparam int AIF_HOST_BYTES = 5;
  localparam int AIF_PAYLOAD    = 10;
  localparam int AIF_PREFIX     = 4;   // three header bytes plus checksum

  localparam logic [7:0] AIF_HDR_TYPE = 8'h84;
  localparam logic [7:0] AIF_HDR_VER  = 8'h01;
  localparam logic [7:0] AIF_HDR_LEN  = 8'h0A;
  localparam logic [7:0] AIF_CA_8CH   = 8'h13;
  localparam logic [2:0] AIF_CC_8CH   = 3'd7;

  localparam int AIF_CC_BYTE = 0;      // data byte 1
  localparam int AIF_CA_BYTE = 3;      // data byte 4

  // Counts 2..6 (three to seven channels) collapse onto the 8-channel code.
  function automatic logic [7:0] aif_fix_cc(input logic [7:0] b);
    return (b[2:0] > 3'd1) ? {b[7:3], AIF_CC_8CH} : b;
  endfunction

  function automatic logic [7:0] aif_fix_ca(input logic [7:0] b);
    return (b != 8'h00) ? AIF_CA_8CH : 8'h00;
  endfunction

  function automatic logic [7:0] aif_checksum(
      input logic [AIF_HOST_BYTES-1:0][7:0] d);
    logic [7:0] acc;
    acc = AIF_HDR_TYPE + AIF_HDR_VER + AIF_HDR_LEN;
    for (int i = 0; i < AIF_HOST_BYTES; i++) acc = acc + d[i];
    return 8'h00 - acc;
  endfunction
endpackage

// File: rtl/aif_field_regs.sv
module aif_field_regs
  import aif_pkg::*;
#(
  parameter int BW = AIF_BW,
  parameter int NB = AIF_HOST_BYTES,
  localparam int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  logic [BW-1:0]         wdata,
  output logic [NB-1:0][BW-1:0] fields,
  output logic [BW-1:0]         csum
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [BW-1:0] fixed;
    if (i == AIF_CC_BYTE) begin : g_cc
      assign fixed = aif_fix_cc(wdata);
    end else if (i == AIF_CA_BYTE) begin : g_ca
      assign fixed = aif_fix_ca(wdata);
    end else begin : g_raw
      assign fixed = wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                          fields[i] <= '0;
      else if (we && (int'(sel) == i))     fields[i] <= fixed;
    end
  end

  assign csum = aif_checksum(fields);
endmodule

// File: rtl/aif_pkt_ctrl.sv
module aif_pkt_ctrl #(
  parameter int PKT_LEN = 14,
  localparam int IDX_W = $clog2(PKT_LEN),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_enable,
  input  logic             ctl_repeat,
  input  logic             frame_tick,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             pkt_start,
  output logic             pkt_done,
  output logic             en_q,
  output logic             rep_q
);
  assign pkt_start = frame_tick && en_q && !busy;
  assign pkt_done  = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (pkt_start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      busy <= !pkt_done;
      idx  <= pkt_done ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rep_q <= 1'b0;
    end else if (ctl_we) begin
      en_q  <= ctl_enable;
      rep_q <= ctl_repeat;
    end else if (pkt_done && !rep_q) begin
      en_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/aif_byte_mux.sv
module aif_byte_mux
  import aif_pkg::*;
#(
  parameter int BW = AIF_BW,
  parameter int NB = AIF_HOST_BYTES,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]      idx,
  input  logic [NB-1:0][BW-1:0] fields,
  input  logic [BW-1:0]         csum,
  output logic [BW-1:0]         byte_o
);
  always_comb begin
    byte_o = '0;
    case (int'(idx))
      0: byte_o = AIF_HDR_TYPE;
      1: byte_o = AIF_HDR_VER;
      2: byte_o = AIF_HDR_LEN;
      3: byte_o = csum;
      default: begin
        for (int i = 0; i < NB; i++)
          if (int'(idx) == AIF_PREFIX + i) byte_o = fields[i];
      end
    endcase
  end
endmodule

// File: rtl/aif_pkt_gen.sv
module aif_pkt_gen
  import aif_pkg::*;
#(
  parameter int BW = AIF_BW,
  parameter int NB = AIF_HOST_BYTES,
  parameter int PAYLOAD = AIF_PAYLOAD,
  localparam int PKT_LEN = AIF_PREFIX + PAYLOAD,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fld_we,
  input  logic [2:0]    fld_sel,
  input  logic [BW-1:0] fld_wdata,
  input  logic          ctl_we,
  input  logic          ctl_enable,
  input  logic          ctl_repeat,
  input  logic          frame_tick,
  output logic          out_valid,
  output logic [BW-1:0] out_byte,
  output logic          out_last
);
  logic [NB-1:0][BW-1:0] fields;
  logic [BW-1:0]         csum;
  logic [BW-1:0]         mux_byte;
  logic [IDX_W-1:0]      seq_idx;
  logic                  busy, pkt_start, pkt_done, en_q, rep_q;

  aif_field_regs #(.BW(BW), .NB(NB)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(fld_we), .sel(fld_sel),
    .wdata(fld_wdata), .fields(fields), .csum(csum)
  );

  aif_pkt_ctrl #(.PKT_LEN(PKT_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_repeat(ctl_repeat), .frame_tick(frame_tick), .busy(busy),
    .idx(seq_idx), .pkt_start(pkt_start), .pkt_done(pkt_done),
    .en_q(en_q), .rep_q(rep_q)
  );

  aif_byte_mux #(.BW(BW), .NB(NB), .IDX_W(IDX_W)) u_mux (
    .idx(seq_idx), .fields(fields), .csum(csum), .byte_o(mux_byte)
  );

  assign out_valid = busy;
  assign out_last  = pkt_done;
  assign out_byte  = busy ? mux_byte : '0;
endmodule

// File: rtl/aif_pkt_gen_chk.sv
module aif_pkt_gen_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_last,
  input logic [7:0]       out_byte,
  input logic             frame_tick,
  input logic             ctl_we,
  input logic [IDX_W-1:0] idx,
  input logic             pkt_start,
  input logic             pkt_done,
  input logic             en_q,
  input logic             rep_q
);
  AST_LAST_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);                                             // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);                             // R2
  AST_START_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (out_valid && out_byte == 8'h84));                     // R7
  AST_FIRST_IS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_byte == 8'h84);                             // R1
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(idx) >= 9) |-> out_byte == 8'h00);               // R4
  AST_CA_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(idx) == 7) |-> (out_byte == 8'h00 || out_byte == 8'h13)); // R5
  AST_CC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(idx) == 4) |-> (out_byte[2:0] <= 3'd1 || out_byte[2:0] == 3'd7)); // R6
  AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !rep_q && !ctl_we) |=> !en_q);                          // R9
  AST_REPEAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && rep_q && en_q && !ctl_we) |=> en_q);                    // R8
  AST_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && frame_tick) |=> idx == IDX_W'($past(idx) + 1'b1)); // R10
endmodule

bind aif_pkt_gen aif_pkt_gen_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_last(out_last),
  .out_byte(out_byte), .frame_tick(frame_tick), .ctl_we(ctl_we),
  .idx(seq_idx), .pkt_start(pkt_start), .pkt_done(pkt_done),
  .en_q(en_q), .rep_q(rep_q)
);

// File: tb/aif_pkt_gen_tb.sv
module aif_pkt_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // data bytes 1..5, element [0] = byte 1
  localparam logic [4:0][7:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h01},   // stereo, CA zero passes
    {8'h11, 8'h05, 8'h22, 8'h0C, 8'h02},   // cc 2 -> 7, CA 05 -> 13
    {8'hA5, 8'h13, 8'h5A, 8'h33, 8'h15},   // cc 5 -> 7
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hF7},   // cc 7 kept, CA FF -> 13
    {8'h40, 8'h00, 8'h00, 8'h1B, 8'h13},   // cc 3 -> 7, CA zero
    {8'h08, 8'h01, 8'h80, 8'h7E, 8'h00}    // cc 0 kept, CA 01 -> 13
  };

  logic clk = 0, rst_n = 0;
  logic fld_we = 0, ctl_we = 0, ctl_enable = 0, ctl_repeat = 0, frame_tick = 0;
  logic [2:0] fld_sel = '0;
  logic [7:0] fld_wdata = '0;
  logic out_valid, out_last;
  logic [7:0] out_byte;
  int n_chk = 0, n_bad = 0;
  logic [7:0] cap [14];
  logic [7:0] exp_p [14];

  always #(CLK_P/2) clk = ~clk;

  aif_pkt_gen dut_i (
    .clk(clk), .rst_n(rst_n), .fld_we(fld_we), .fld_sel(fld_sel),
    .fld_wdata(fld_wdata), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
    .ctl_repeat(ctl_repeat), .frame_tick(frame_tick), .out_valid(out_valid),
    .out_byte(out_byte), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Packet as the requirements describe it.
  task automatic build_expected(input logic [4:0][7:0] v);
    logic [7:0] s;
    exp_p[0] = 8'h84; exp_p[1] = 8'h01; exp_p[2] = 8'h0A;
    exp_p[4] = v[0];
    if (v[0][2:0] >= 3'd2) exp_p[4][2:0] = 3'd7;
    exp_p[5] = v[1]; exp_p[6] = v[2];
    exp_p[7] = (v[3] == 8'h00) ? 8'h00 : 8'h13;
    exp_p[8] = v[4];
    for (int k = 9; k < 14; k++) exp_p[k] = 8'h00;
    s = 8'h00;
    for (int k = 0; k < 14; k++) if (k != 3) s = s + exp_p[k];
    exp_p[3] = 8'(9'h100 - {1'b0, s});
  endtask

  task automatic wr_field(input int sel, input logic [7:0] v);
    @(negedge clk); fld_we = 1; fld_sel = 3'(sel); fld_wdata = v;
    @(negedge clk); fld_we = 0;
  endtask

  task automatic wr_ctl(input logic en, input logic rep);
    @(negedge clk); ctl_we = 1; ctl_enable = en; ctl_repeat = rep;
    @(negedge clk); ctl_we = 0;
  endtask

  // Pulse a slot request; return at the negedge where byte 0 should show.
  task automatic tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  // Capture 14 bytes starting at the current negedge; check framing (R2).
  task automatic grab();
    int bad_frame = 0;
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      cap[k] = out_byte;
      if (out_valid !== 1'b1 || out_last !== (k == 13)) bad_frame++;
    end
    check("R2 framing errors", bad_frame, 0);
    @(negedge clk);
    check("R2 idle after last", out_valid, 0);
  endtask

  task automatic count_valid(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      if (out_valid) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 valid low after reset", out_valid, 0);

    // R7: disabled block ignores slot requests (R11: enable clear)
    tick();
    count_valid(16, n);
    check("R7/R11 no packet while disabled", n, 0);

    // R11: reset data bytes zero -> checksum 0x71
    wr_ctl(1, 1);
    tick();
    grab();
    check("R11 reset checksum", cap[3], 8'h71);
    check("R11 reset data byte 1", cap[4], 8'h00);

    // Table walk: R1 R3 R4 R5 R6 R12 with repeat on (R8)
    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < 5; b++) wr_field(b, VEC[v][b]);
      build_expected(VEC[v]);
      tick();
      grab();
      for (int k = 0; k < 3; k++) check("R1 header", cap[k], exp_p[k]);
      check("R3 checksum", cap[3], exp_p[3]);
      check("R6 data byte 1", cap[4], exp_p[4]);
      check("R12 data byte 2", cap[5], exp_p[5]);
      check("R12 data byte 3", cap[6], exp_p[6]);
      check("R5 data byte 4", cap[7], exp_p[7]);
      check("R12 data byte 5", cap[8], exp_p[8]);
      for (int k = 9; k < 14; k++) check("R4 zero tail", cap[k], 8'h00);
      s = 8'h00;
      for (int k = 0; k < 14; k++) s = s + cap[k];
      check("R3 packet sum", s, 8'h00);
    end

    // R8: repeat keeps sending with no host action
    tick();
    grab();
    check("R8 repeated packet header", cap[0], 8'h84);
    check("R8 repeated checksum", cap[3], exp_p[3]);

    // R10: slot request mid-packet is ignored
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    repeat (5) @(negedge clk);
    frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    count_valid(30, n);
    check("R10 valid cycles with mid-packet tick", n, 8);

    // R9: one-shot sends once then disables
    wr_ctl(1, 0);
    tick();
    grab();
    check("R9 one-shot packet sent", cap[0], 8'h84);
    tick();
    count_valid(20, n);
    check("R9 no second packet", n, 0);
    wr_ctl(1, 0);
    tick();
    grab();
    check("R9 re-enable sends again", cap[2], 8'h0A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule